// File: doc/BRIEF.md
# I2C Register Target with Strap-Selected Address

This block is an I2C target that lets a bus host read and write a bank of byte-wide registers. The bank sits outside the block and is reached through a plain register port. The block samples SCL and SDA with its own system clock and runs a two-flop synchronizer on each line. It detects edges, START, repeated START and STOP on the synchronized values. Its only drive onto the bus is an open-drain enable that pulls SDA low.

A transfer begins with a 7-bit address. Five upper address bits are fixed, and the strap input picks one of two low-bit patterns. A write transfer then carries a pointer byte. The low seven bits of that byte select the register, and its top bit turns on pointer advance after every data byte. Data bytes that follow are written at the pointer. A read places the pointer with a write transfer, then issues a repeated START with the read direction. Bytes are then shifted out most significant bit first until the host refuses one.

Top module: `i2c_reg_target`

## Requirements
- R1: After reset the block releases SDA (sda_oe_o = 0) and issues no register write.
- R2: The address byte is the 7-bit address in bits 7..1 and the direction in bit 0 (1 = host reads). With strap_i = 1 the block answers address 0x1D, and with strap_i = 0 it answers 0x1E. It acknowledges a match by holding SDA low through the high phase of the ninth clock.
- R3: After an address that does not match, the block never drives SDA and writes nothing until the next START or STOP.
- R4: In a write transfer the block acknowledges the address byte, the pointer byte and every data byte. Each data byte is written to the register at the current pointer.
- R5: When bit 7 of the pointer byte is 1, the pointer, taken from bits 6..0, advances by one after each data byte, whether written or read. It wraps from 127 to 0.
- R6: When bit 7 of the pointer byte is 0, every data byte in the transfer accesses the same register.
- R7: A read starts with a repeated START and the address with bit 0 = 1. The block returns the register at the pointer, most significant bit first. SDA changes only while SCL is low and stays stable while SCL is high.
- R8: A host acknowledge after a read byte makes the block send the next byte. A host non-acknowledge makes it release SDA and stay off the bus until a START or STOP.
- R9: A START or STOP in the middle of a byte aborts that byte. No register is written from it, and a following transfer works normally.
- R10: A STOP releases SDA and returns the block to idle.
- R11: Each written data byte produces a write strobe exactly one clock long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| strap_i | input | 1 | Address select strap |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| reg_addr_o | output | REG_AW | Register pointer for reads and writes |
| reg_wdata_o | output | 8 | Data byte to write |
| reg_we_o | output | 1 | One-clock write strobe |
| reg_rdata_i | input | 8 | Register content at reg_addr_o, combinational |

## Verification
A wrong protocol state shows up within one byte time as a missing or extra acknowledge on SDA, a read byte with the wrong value, or a write strobe with the wrong address or data. The bench's register scoreboard catches these at the next strobe or at the end of the next read byte. A pointer that steps wrongly becomes visible at the second byte of a burst, and wrap errors at the crossing from 127 to 0. A failure to abort on a mid-byte START or STOP appears as a stray write strobe, or as a lost acknowledge in the transfer that follows.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RDATA_ACK,
    ST_IGNORE
  } tgt_state_e;
endpackage

// File: rtl/i2c_sync_edge.sv
module i2c_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_i;
          sda_pipe[g] <= sda_i;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          scl_pipe[g] <= 1'b1;
          sda_pipe[g] <= 1'b1;
        end else begin
          scl_pipe[g] <= scl_pipe[g-1];
          sda_pipe[g] <= sda_pipe[g-1];
        end
      end
    end
  end

  assign scl_s_o = scl_pipe[STAGES-1];
  assign sda_s_o = sda_pipe[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_o;
      sda_q <= sda_s_o;
    end
  end

  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  // SDA edge with SCL steady high
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;
endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
  parameter int unsigned AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          ainc_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o,
  output logic          ainc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o  <= '0;
      ainc_o <= 1'b0;
    end else if (load_i) begin
      ptr_o  <= load_val_i;
      ainc_o <= ainc_i;
    end else if (step_i && ainc_o) begin
      ptr_o  <= ptr_o + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned AW          = 7,
  parameter logic [4:0]  DEV_ADDR_HI = 5'b00111,
  parameter logic [1:0]  ADDR_SEL_HI = 2'b01,
  parameter logic [1:0]  ADDR_SEL_LO = 2'b10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              strap_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sda_oe_o,
  output logic              we_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              ptr_load_o,
  output logic [AW-1:0]     ptr_val_o,
  output logic              ptr_ainc_o,
  output logic              ptr_step_o,
  output tgt_state_e        state_o,
  output logic [CNT_W-1:0]  bit_cnt_o
);
  localparam logic [6:0]       ADDR_HI  = {DEV_ADDR_HI, ADDR_SEL_HI};
  localparam logic [6:0]       ADDR_LO  = {DEV_ADDR_HI, ADDR_SEL_LO};
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  tgt_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shift;
  logic              rnw;
  logic              host_ack;
  logic [6:0]        dev_addr;
  logic              byte_done;

  assign dev_addr  = strap_i ? ADDR_HI : ADDR_LO;
  assign byte_done = scl_fall_i && (cnt == CNT_FULL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      shift      <= '0;
      rnw        <= 1'b0;
      host_ack   <= 1'b0;
      sda_oe_o   <= 1'b0;
      we_o       <= 1'b0;
      wdata_o    <= '0;
      ptr_load_o <= 1'b0;
      ptr_step_o <= 1'b0;
    end else begin
      we_o       <= 1'b0;
      ptr_load_o <= 1'b0;
      ptr_step_o <= 1'b0;
      if (start_i) begin
        state    <= ST_ADDR;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state    <= ST_IDLE;
        cnt      <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE, ST_IGNORE: ;
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise_i && cnt != CNT_FULL) begin
              shift <= {shift[BYTE_W-2:0], sda_s_i};
              cnt   <= cnt + 1'b1;
            end else if (byte_done) begin
              cnt <= '0;
              if (state == ST_ADDR) begin
                if (shift[7:1] == dev_addr) begin
                  rnw      <= shift[0];
                  sda_oe_o <= 1'b1;
                  state    <= ST_ADDR_ACK;
                end else begin
                  state <= ST_IGNORE;
                end
              end else if (state == ST_SUB) begin
                ptr_load_o <= 1'b1;
                sda_oe_o   <= 1'b1;
                state      <= ST_SUB_ACK;
              end else begin
                we_o     <= 1'b1;
                wdata_o  <= shift;
                sda_oe_o <= 1'b1;
                state    <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              if (rnw) begin
                shift    <= rdata_i;
                sda_oe_o <= ~rdata_i[BYTE_W-1];
                state    <= ST_RDATA;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              state    <= ST_WDATA;
            end
          end
          ST_WDATA_ACK: begin
            if (scl_fall_i) begin
              sda_oe_o   <= 1'b0;
              ptr_step_o <= 1'b1;
              state      <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise_i && cnt != CNT_FULL) begin
              cnt <= cnt + 1'b1;
            end else if (byte_done) begin
              cnt        <= '0;
              sda_oe_o   <= 1'b0;
              ptr_step_o <= 1'b1;
              state      <= ST_RDATA_ACK;
            end else if (scl_fall_i && cnt != '0) begin
              shift    <= {shift[BYTE_W-2:0], 1'b0};
              sda_oe_o <= ~shift[BYTE_W-2];
            end
          end
          ST_RDATA_ACK: begin
            if (scl_rise_i) begin
              host_ack <= ~sda_s_i;
            end else if (scl_fall_i) begin
              if (host_ack) begin
                shift    <= rdata_i;
                sda_oe_o <= ~rdata_i[BYTE_W-1];
                state    <= ST_RDATA;
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign ptr_val_o  = shift[AW-1:0];
  assign ptr_ainc_o = shift[BYTE_W-1];
  assign state_o    = state;
  assign bit_cnt_o  = cnt;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned REG_AW      = 7,
  parameter logic [4:0]  DEV_ADDR_HI = 5'b00111,
  parameter logic [1:0]  ADDR_SEL_HI = 2'b01,
  parameter logic [1:0]  ADDR_SEL_LO = 2'b10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              strap_i,
  output logic              sda_oe_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [BYTE_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  input  logic [BYTE_W-1:0] reg_rdata_i
);
  logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              ptr_load, ptr_ainc, ptr_step, ainc_q;
  logic [REG_AW-1:0] ptr_val, ptr;
  tgt_state_e        state;
  logic [CNT_W-1:0]  bit_cnt;

  i2c_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_tgt_fsm #(
    .AW          (REG_AW),
    .DEV_ADDR_HI (DEV_ADDR_HI),
    .ADDR_SEL_HI (ADDR_SEL_HI),
    .ADDR_SEL_LO (ADDR_SEL_LO)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .strap_i    (strap_i),
    .rdata_i    (reg_rdata_i),
    .sda_oe_o   (sda_oe_o),
    .we_o       (reg_we_o),
    .wdata_o    (reg_wdata_o),
    .ptr_load_o (ptr_load),
    .ptr_val_o  (ptr_val),
    .ptr_ainc_o (ptr_ainc),
    .ptr_step_o (ptr_step),
    .state_o    (state),
    .bit_cnt_o  (bit_cnt)
  );

  i2c_reg_ptr #(.AW(REG_AW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (ptr_load),
    .load_val_i (ptr_val),
    .ainc_i     (ptr_ainc),
    .step_i     (ptr_step),
    .ptr_o      (ptr),
    .ainc_o     (ainc_q)
  );

  assign reg_addr_o = ptr;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned AW = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sda_oe_o,
  input logic             reg_we_o,
  input logic             scl_s,
  input logic             start_det,
  input logic             stop_det,
  input tgt_state_e       state,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [AW-1:0]    ptr,
  input logic             ptr_load
);
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr;
  end
  assign ptr_nxt = ptr_q + 1'b1;

  // R7
  sda_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s));

  // R11
  we_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  // R10
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (!sda_oe_o && state == ST_IDLE));

  // R9
  start_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (bit_cnt == '0 && state == ST_ADDR));

  // R3
  ignore_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IGNORE) |-> (!sda_oe_o && !reg_we_o));

  // R5
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr != ptr_q) |-> ((ptr == ptr_nxt) || $past(ptr_load)));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.AW(REG_AW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sda_oe_o  (sda_oe_o),
  .reg_we_o  (reg_we_o),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .state     (state),
  .bit_cnt   (bit_cnt),
  .ptr       (ptr),
  .ptr_load  (ptr_load)
);

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_drv = 1'b1;
  logic       sda_drv = 1'b1;
  logic       strap = 1'b1;
  logic       sda_line;
  logic       sda_oe;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       reg_we;

  logic [7:0]  mem     [128];
  logic [7:0]  exp_mem [128];
  logic [14:0] exp_q[$];
  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  assign sda_line  = sda_drv & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_reg_target dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl_drv),
    .sda_i       (sda_line),
    .strap_i     (strap),
    .sda_oe_o    (sda_oe),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_we_o    (reg_we),
    .reg_rdata_i (reg_rdata)
  );

  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Scoreboard monitor: one pop per write strobe cycle (R4, R11)
  always @(negedge clk) begin
    if (rst_n && reg_we) begin
      if (exp_q.size() == 0) begin
        chk("R3/R9/R11 unexpected write", {reg_addr, reg_wdata}, 'h7fff);
      end else begin
        logic [14:0] e;
        e = exp_q.pop_front();
        chk("R4 write addr/data", {reg_addr, reg_wdata}, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b0; tick(Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(Q);
    scl_drv = 1'b1; tick(Q);
    sda_drv = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_drv = b;    tick(Q);
    scl_drv = 1'b1; tick(2 * Q);
    scl_drv = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b, output logic stable);
    logic b0, b1;
    sda_drv = 1'b1; tick(Q);
    scl_drv = 1'b1; tick(Q);
    b0 = sda_line;  tick(Q);
    b1 = sda_line;
    scl_drv = 1'b0; tick(Q);
    b = b0;
    stable = (b0 == b1);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic a, s;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(a, s);
    ack = ~a;
  endtask

  task automatic recv_byte(output logic [7:0] d, output logic stable, input logic host_ack);
    logic b, s;
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b, s);
      d[i] = b;
      stable &= s;
    end
    put_bit(~host_ack);
  endtask

  function automatic logic [6:0] dev_addr();
    return strap ? 7'h1D : 7'h1E;
  endfunction

  // Write n bytes d0, d0+0x11, ... starting at pointer byte sub
  task automatic do_write(input logic [7:0] sub, input logic [7:0] d0, input int n);
    logic ack;
    logic [6:0] a;
    logic [7:0] d;
    bus_start();
    send_byte({dev_addr(), 1'b0}, ack); chk("R2/R4 addr ack", ack, 1);
    send_byte(sub, ack);                chk("R4 sub ack", ack, 1);
    a = sub[6:0];
    for (int i = 0; i < n; i++) begin
      d = d0 + 8'(i * 8'h11);
      exp_q.push_back({a, d});
      exp_mem[a] = d;
      send_byte(d, ack); chk("R4 data ack", ack, 1);
      if (sub[7]) a = a + 7'd1;   // R5 / R6
    end
    bus_stop();
    tick(Q);
    chk("R10 sda released after stop", sda_oe, 0);
  endtask

  task automatic do_read(input logic [7:0] sub, input int n, input string req);
    logic ack, st;
    logic [6:0] a;
    logic [7:0] d;
    bus_start();
    send_byte({dev_addr(), 1'b0}, ack); chk("R7 addr W ack", ack, 1);
    send_byte(sub, ack);                chk("R7 sub ack", ack, 1);
    bus_start();
    send_byte({dev_addr(), 1'b1}, ack); chk("R7 addr R ack", ack, 1);
    a = sub[6:0];
    for (int i = 0; i < n; i++) begin
      recv_byte(d, st, i != n - 1);
      chk(req, d, exp_mem[a]);
      chk("R7 sda stable while scl high", st, 1);
      if (sub[7]) a = a + 7'd1;
    end
    chk("R8 released after host nack", sda_oe, 0);
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin
      mem[i]     = 8'(i * 37 + 5);
      exp_mem[i] = 8'(i * 37 + 5);
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ack, st;
    logic [7:0] d;
    tick(5);
    chk("R1 sda released in reset", sda_oe, 0);
    rst_n = 1'b1;
    tick(5);
    chk("R1 sda released after reset", sda_oe, 0);
    chk("R1 no write after reset", reg_we, 0);

    // R4 single write, strap high
    do_write(8'h05, 8'hA5, 1);
    // R5 burst with wrap 7E,7F,00
    do_write(8'hFE, 8'h31, 3);
    // R6 burst without increment
    do_write(8'h10, 8'h42, 2);

    // R7 single read, R5 burst read over wrap, R6 repeated register
    do_read(8'h05, 1, "R7 read value MSB first");
    do_read(8'hFE, 3, "R5 burst read auto-increment");
    do_read(8'h10, 2, "R6 burst read same register");

    // R8: after host nack the block stays off the bus for a full byte
    bus_start();
    send_byte({dev_addr(), 1'b0}, ack);
    send_byte(8'h05, ack);
    bus_start();
    send_byte({dev_addr(), 1'b1}, ack);
    recv_byte(d, st, 1'b0);
    chk("R8 first byte", d, exp_mem[5]);
    recv_byte(d, st, 1'b0);
    chk("R8 no drive after nack", d, 8'hFF);
    bus_stop();

    // R3 non-matching address with strap high
    bus_start();
    send_byte({7'h1E, 1'b0}, ack); chk("R3 no ack on mismatch", ack, 0);
    send_byte(8'h05, ack);         chk("R3 no ack on sub", ack, 0);
    send_byte(8'h77, ack);         chk("R3 no ack on data", ack, 0);
    chk("R3 sda released", sda_oe, 0);
    bus_stop();
    do_read(8'h05, 1, "R3 register untouched");

    // R2 strap low selects 0x1E
    strap = 1'b0;
    tick(Q);
    do_write(8'h40, 8'h99, 1);
    bus_start();
    send_byte({7'h1D, 1'b0}, ack); chk("R2 strap low rejects 0x1D", ack, 0);
    bus_stop();
    do_read(8'h40, 1, "R2 strap low read");

    // R9 START mid-byte aborts
    bus_start();
    send_byte({dev_addr(), 1'b0}, ack);
    send_byte(8'h20, ack);
    for (int i = 0; i < 4; i++) put_bit(1'b1);
    bus_start();
    send_byte({dev_addr(), 1'b0}, ack); chk("R9 addr ack after abort", ack, 1);
    send_byte(8'h21, ack);              chk("R9 sub ack after abort", ack, 1);
    exp_q.push_back({7'h21, 8'h3C});
    exp_mem[7'h21] = 8'h3C;
    send_byte(8'h3C, ack);              chk("R9 data ack after abort", ack, 1);
    bus_stop();
    // R9 STOP mid-byte aborts
    bus_start();
    send_byte({dev_addr(), 1'b0}, ack);
    send_byte(8'h22, ack);
    for (int i = 0; i < 3; i++) put_bit(1'b0);
    bus_stop();
    tick(Q);
    chk("R10 idle release after mid-byte stop", sda_oe, 0);
    do_read(8'h20, 1, "R9 partial byte not written");
    do_read(8'h22, 1, "R9 partial byte not written");
    do_read(8'h21, 1, "R9 write after abort");

    tick(4 * Q);
    chk("R4 all expected writes seen", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule